// File: doc/BRIEF.md
# Per-core prioritized interrupt controller

This block collects the interrupt sources of one processor core into a single request line. Each source owns three pieces of state: a sticky pending bit, an enable bit and a priority level. Most sources are hardware lines, and a rising edge on one of them latches its pending bit. A configurable group of sources has no hardware line at all, and only software can make those pending. Software reaches every register through a simple single-cycle register bus.

The block raises `irq_req_o` whenever a source is pending and enabled and its priority is strictly above the core's running interrupt level. When the core takes the interrupt with `irq_take_i`, the block records the winning source number as the cause and lifts the running level to the winner's priority. The handler rebuilds a one-hot mask from the cause and clears pending bits in bulk by mask. It then writes the level back to zero, so requests of any priority can be taken again.

Register map on `reg_addr_i`:
- 0x0: pending. A read returns the pending bits. A write ORs in the written mask.
- 0x1: pending clear. A write clears the masked bits. A read returns the pending bits.
- 0x2: enable. A read returns the enable bits. A write ORs in the written mask.
- 0x3: enable clear. A write clears the masked bits. A read returns the enable bits.
- 0x4: running level, held in bits [3:0].
- 0x5: cause, held in bits [4:0]. It can only be read.
- 0x8 to 0xB: priority words. Word k holds source 8k+j in bits [4j+3:4j].

Unmapped reads return 0.

Top module: `core_irq_arbiter`

## Requirements
- R1: After reset, the following are all 0: every pending bit, every enable bit, every priority, the running level and the cause. `irq_req_o` is low.
- R2: A hardware source (0–17 and 24–31 by default) latches its pending bit in the clock edge that first samples its input high.
  - A line that stays high does not set the bit again after it is cleared.
  - The inputs of sources 18–23 are ignored.
- R3: A write to 0x0 sets the written bits and a write to 0x1 clears them, for any source.
  - A hardware rising edge in the same cycle as a clear of that bit leaves the bit set.
- R4: A write to 0x2 sets enable bits and a write to 0x3 clears them. The result reads back at 0x2.
- R5: `irq_req_o` is high exactly when some source is pending, enabled and has a priority strictly greater than the running level.
- R6: The winner is the eligible source with the highest priority. Among equal priorities, the lowest source number wins. The cause is that source's number in binary.
- R7: At a clock edge where `irq_take_i` and `irq_req_o` are both high, the running level becomes the winner's priority and the cause becomes the winner's number.
  - A take without a request changes neither.
  - The cause changes at no other time.
- R8: A source with priority 0 never raises a request. Clearing a source's enable masks its request but leaves its pending bit unchanged.
- R9: A write to 0x4 sets the running level from bits [3:0] of the write data. If a take happens in the same cycle, the take wins.
- R10: The priority of source 8k+j is written and read in word 0x8+k, bits [4j+3:4j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq_i | input | 32 | Hardware interrupt lines, rising-edge sensitive |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the addressed register, combinational |
| irq_take_i | input | 1 | Core takes the current request |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_cause_o | output | 5 | Number of the last source taken |
| irq_level_o | output | 4 | Running interrupt level of the core |

## Verification
The bound checker watches several rules on every cycle:
- A take lifts the level to the arbiter's winning priority.
- The level and the cause stay still when neither a take nor a level write occurs.
- A request always carries a winning priority above the level.
- Each hardware rising edge lands in the pending register.
- The software-only bits never rise without a pending write.
- A clear of enables never drops a pending bit.

Only the bench scenarios show the following:
- The choice among several eligible sources, including ties and the masking effect of priority 0.
- The race between an edge and a clear.
- The placement of priority fields in the word map.
- The agreement of the read-back registers with a reference model under random traffic.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   localparam int DATA_W = 32;
   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] RA_PEND_SET = 4'h0;
   localparam logic [ADDR_W-1:0] RA_PEND_CLR = 4'h1;
   localparam logic [ADDR_W-1:0] RA_EN_SET   = 4'h2;
   localparam logic [ADDR_W-1:0] RA_EN_CLR   = 4'h3;
   localparam logic [ADDR_W-1:0] RA_LEVEL    = 4'h4;
   localparam logic [ADDR_W-1:0] RA_CAUSE    = 4'h5;
   localparam logic [ADDR_W-1:0] RA_PRIO     = 4'h8;

   localparam int MAX_PRIO_WORDS = 8;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] hw_i,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);

   genvar g;
   generate
      for (g = 0; g < NUM_SRC; g++) begin : g_src
         logic prev_q;
         logic pend_q;
         logic rise;

         assign rise = hw_i[g] & ~prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= hw_i[g];
               // a rising edge outranks a clear in the same cycle
               pend_q <= (pend_q & ~clr_i[g]) | set_i[g] | rise;
            end
         end

         assign pend_o[g] = pend_q;
      end
   endgenerate

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
   import irq_arb_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4,
   parameter int ID_W    = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [DATA_W-1:0]         wdata_i,
   input  logic [NUM_SRC-1:0]        pend_i,
   input  logic [PRIO_W-1:0]         level_i,
   input  logic [ID_W-1:0]           cause_i,
   output logic [NUM_SRC-1:0]        pend_set_o,
   output logic [NUM_SRC-1:0]        pend_clr_o,
   output logic [NUM_SRC-1:0]        en_o,
   output logic [NUM_SRC*PRIO_W-1:0] prio_o,
   output logic                      level_wr_o,
   output logic [DATA_W-1:0]         rdata_o
);

   localparam int PER_WORD = DATA_W / PRIO_W;
   localparam int N_WORDS  = NUM_SRC / PER_WORD;

   logic [NUM_SRC-1:0] en_q;

   assign pend_set_o = (wr_i && addr_i == RA_PEND_SET) ? wdata_i[NUM_SRC-1:0] : '0;
   assign pend_clr_o = (wr_i && addr_i == RA_PEND_CLR) ? wdata_i[NUM_SRC-1:0] : '0;
   assign level_wr_o = wr_i && (addr_i == RA_LEVEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_i && addr_i == RA_EN_SET) begin
         en_q <= en_q | wdata_i[NUM_SRC-1:0];
      end else if (wr_i && addr_i == RA_EN_CLR) begin
         en_q <= en_q & ~wdata_i[NUM_SRC-1:0];
      end
   end

   assign en_o = en_q;

   genvar w;
   generate
      for (w = 0; w < N_WORDS; w++) begin : g_prio_word
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (wr_i && addr_i == (RA_PRIO + ADDR_W'(w))) begin
               word_q <= wdata_i;
            end
         end
         assign prio_o[w*DATA_W +: DATA_W] = word_q;
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         RA_PEND_SET, RA_PEND_CLR: rdata_o = DATA_W'(pend_i);
         RA_EN_SET, RA_EN_CLR:     rdata_o = DATA_W'(en_q);
         RA_LEVEL:                 rdata_o = DATA_W'(level_i);
         RA_CAUSE:                 rdata_o = DATA_W'(cause_i);
         default: begin
            for (int k = 0; k < N_WORDS; k++) begin
               if (addr_i == (RA_PRIO + ADDR_W'(k))) begin
                  rdata_o = prio_o[k*DATA_W +: DATA_W];
               end
            end
         end
      endcase
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4,
   parameter int ID_W    = 5
) (
   input  logic [NUM_SRC-1:0]        cand_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]         level_i,
   output logic                      req_o,
   output logic [ID_W-1:0]           win_id_o,
   output logic [PRIO_W-1:0]         win_prio_o
);

   always_comb begin
      win_prio_o = '0;
      win_id_o   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         // strict compare keeps the lowest number on a tie
         if (cand_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > level_i) &&
             (prio_i[i*PRIO_W +: PRIO_W] > win_prio_o)) begin
            win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
            win_id_o   = ID_W'(i);
         end
      end
      // an eligible source always has a nonzero priority
      req_o = (win_prio_o != '0);
   end

endmodule

// File: rtl/core_irq_arbiter.sv
module core_irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int                 NUM_SRC = 32,
   parameter int                 PRIO_W  = 4,
   parameter logic [NUM_SRC-1:0] HW_MASK = 32'hFF03_FFFF,
   localparam int                ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] hw_irq_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   input  logic               irq_take_i,
   output logic               irq_req_o,
   output logic [ID_W-1:0]    irq_cause_o,
   output logic [PRIO_W-1:0]  irq_level_o
);

   generate
      if (NUM_SRC < 2 || NUM_SRC > DATA_W) begin : g_bad_count
         $error("core_irq_arbiter: NUM_SRC must lie in 2..DATA_W");
      end
      if (PRIO_W < 1 || (DATA_W % PRIO_W) != 0) begin : g_bad_prio
         $error("core_irq_arbiter: PRIO_W must divide DATA_W");
      end else if ((NUM_SRC % (DATA_W / PRIO_W)) != 0 ||
                   (NUM_SRC / (DATA_W / PRIO_W)) > MAX_PRIO_WORDS) begin : g_bad_words
         $error("core_irq_arbiter: priority words must be whole and fit the map");
      end
   endgenerate

   logic [NUM_SRC-1:0]        hw_lines;
   logic [NUM_SRC-1:0]        pend_q;
   logic [NUM_SRC-1:0]        en_q;
   logic [NUM_SRC-1:0]        pend_set;
   logic [NUM_SRC-1:0]        pend_clr;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic                      level_wr;
   logic                      req;
   logic [ID_W-1:0]           win_id;
   logic [PRIO_W-1:0]         win_prio;
   logic [PRIO_W-1:0]         level_q;
   logic [ID_W-1:0]           cause_q;
   logic                      take_ok;

   // software-only sources never see their line
   assign hw_lines = hw_irq_i & HW_MASK;

   irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_i   (hw_lines),
      .set_i  (pend_set),
      .clr_i  (pend_clr),
      .pend_o (pend_q)
   );

   irq_regfile #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (reg_wr_i),
      .addr_i     (reg_addr_i),
      .wdata_i    (reg_wdata_i),
      .pend_i     (pend_q),
      .level_i    (level_q),
      .cause_i    (cause_q),
      .pend_set_o (pend_set),
      .pend_clr_o (pend_clr),
      .en_o       (en_q),
      .prio_o     (prio_flat),
      .level_wr_o (level_wr),
      .rdata_o    (reg_rdata_o)
   );

   irq_prio_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
      .cand_i     (pend_q & en_q),
      .prio_i     (prio_flat),
      .level_i    (level_q),
      .req_o      (req),
      .win_id_o   (win_id),
      .win_prio_o (win_prio)
   );

   assign take_ok = irq_take_i & req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         cause_q <= '0;
      end else if (take_ok) begin
         level_q <= win_prio;
         cause_q <= win_id;
      end else if (level_wr) begin
         level_q <= reg_wdata_i[PRIO_W-1:0];
      end
   end

   assign irq_req_o   = req;
   assign irq_cause_o = cause_q;
   assign irq_level_o = level_q;

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker
   import irq_arb_pkg::*;
#(
   parameter int                 NUM_SRC = 32,
   parameter int                 PRIO_W  = 4,
   parameter logic [NUM_SRC-1:0] HW_MASK = 32'hFF03_FFFF,
   parameter int                 ID_W    = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] hw_irq_i,
   input logic               reg_wr_i,
   input logic [ADDR_W-1:0]  reg_addr_i,
   input logic               irq_take_i,
   input logic               irq_req_o,
   input logic [ID_W-1:0]    irq_cause_o,
   input logic [PRIO_W-1:0]  irq_level_o,
   input logic [NUM_SRC-1:0] pend,
   input logic [PRIO_W-1:0]  win_prio
);

   logic [NUM_SRC-1:0] hw_prev;
   logic [NUM_SRC-1:0] edge_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hw_prev <= '0;
      else        hw_prev <= hw_irq_i;
   end

   assign edge_vec = hw_irq_i & ~hw_prev & HW_MASK;

   p_take_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take_i && irq_req_o) |=> (irq_level_o == $past(win_prio)));

   p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(irq_take_i && irq_req_o) && !(reg_wr_i && reg_addr_i == RA_LEVEL))
      |=> $stable(irq_level_o));

   p_cause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_take_i && irq_req_o) |=> $stable(irq_cause_o));

   p_req_above_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (win_prio > irq_level_o));

   p_edge_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_vec != '0) |=> ((pend & $past(edge_vec)) == $past(edge_vec)));

   p_swonly_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_i && reg_addr_i == RA_PEND_SET)
      |=> (((pend & ~$past(pend)) & ~HW_MASK) == '0));

   p_disable_keeps_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == RA_EN_CLR) |=> ((pend & $past(pend)) == $past(pend)));

endmodule

bind core_irq_arbiter irq_arb_checker #(
   .NUM_SRC (NUM_SRC),
   .PRIO_W  (PRIO_W),
   .HW_MASK (HW_MASK),
   .ID_W    (ID_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hw_irq_i    (hw_irq_i),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .irq_take_i  (irq_take_i),
   .irq_req_o   (irq_req_o),
   .irq_cause_o (irq_cause_o),
   .irq_level_o (irq_level_o),
   .pend        (pend_q),
   .win_prio    (win_prio)
);

// File: tb/tb_core_irq_arbiter.sv
module tb_core_irq_arbiter;

   localparam logic [31:0] HWM = 32'hFF03_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] hw_irq = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_take = 1'b0;
   logic        irq_req;
   logic [4:0]  irq_cause;
   logic [3:0]  irq_level;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   logic [31:0] m_pend = '0, m_en = '0, m_hwp = '0;
   logic [3:0]  m_prio [32];
   logic [3:0]  m_level = '0;
   logic [4:0]  m_cause = '0;

   always #2.5 clk = ~clk;

   core_irq_arbiter dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .hw_irq_i    (hw_irq),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_take_i  (irq_take),
      .irq_req_o   (irq_req),
      .irq_cause_o (irq_cause),
      .irq_level_o (irq_level)
   );

   function automatic logic [9:0] pick();
      logic [3:0] bp = '0;
      logic [4:0] bi = '0;
      for (int i = 0; i < 32; i++) begin
         if (m_pend[i] && m_en[i] && m_prio[i] > m_level && m_prio[i] > bp) begin
            bp = m_prio[i];
            bi = 5'(i);
         end
      end
      return {bp != 4'd0, bi, bp};
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      logic [9:0]  w;
      logic [31:0] edge_v, pn, en_n;
      logic [3:0]  lv;
      logic [4:0]  cs;
      edge_v = hw_irq & ~m_hwp & HWM;
      w = pick();
      pn = m_pend;
      en_n = m_en;
      lv = m_level;
      cs = m_cause;
      if (reg_wr && reg_addr == 4'h0) pn = pn | reg_wdata;
      if (reg_wr && reg_addr == 4'h1) pn = pn & ~reg_wdata;
      pn = pn | edge_v;
      if (reg_wr && reg_addr == 4'h2) en_n = en_n | reg_wdata;
      if (reg_wr && reg_addr == 4'h3) en_n = en_n & ~reg_wdata;
      if (irq_take && w[9]) begin
         lv = w[3:0];
         cs = w[8:4];
      end else if (reg_wr && reg_addr == 4'h4) begin
         lv = reg_wdata[3:0];
      end
      @(posedge clk);
      if (reg_wr && reg_addr >= 4'h8 && reg_addr <= 4'hB) begin
         for (int j = 0; j < 8; j++) m_prio[(reg_addr - 4'h8) * 8 + j] = reg_wdata[4*j +: 4];
      end
      m_pend = pn;
      m_en = en_n;
      m_level = lv;
      m_cause = cs;
      m_hwp = hw_irq;
      @(negedge clk);
      reg_wr = 1'b0;
      irq_take = 1'b0;
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      tick();
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      reg_wr = 1'b0;
      reg_addr = a;
      #0.5;
      chk(reg_rdata, exp, tag);
   endtask

   task automatic check_model(input string tag);
      logic [9:0] w;
      w = pick();
      chk(32'(irq_req), 32'(w[9]), {tag, " R5 request"});
      chk(32'(irq_level), 32'(m_level), {tag, " R7 level"});
      chk(32'(irq_cause), 32'(m_cause), {tag, " R7 cause"});
      rd(4'h0, m_pend, {tag, " R3 pending"});
      rd(4'h2, m_en, {tag, " R4 enable"});
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd2024));
      for (int i = 0; i < 32; i++) m_prio[i] = 4'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(32'(irq_req), 0, "R1 request after reset");
      chk(32'(irq_level), 0, "R1 level after reset");
      chk(32'(irq_cause), 0, "R1 cause after reset");
      rd(4'h0, 0, "R1 pending after reset");
      rd(4'h2, 0, "R1 enable after reset");
      rd(4'h9, 0, "R1 priority after reset");

      // R10 field placement, R6 tie to lowest number
      bus_wr(4'h8, 32'h0000_5000);
      bus_wr(4'h9, 32'h0000_0050);
      rd(4'h8, 32'h0000_5000, "R10 priority word 0");
      rd(4'h9, 32'h0000_0050, "R10 priority word 1");
      bus_wr(4'h2, 32'h0000_0208);
      bus_wr(4'h0, 32'h0000_0208);
      chk(32'(irq_req), 1, "R5 request with eligible sources");
      irq_take = 1'b1;
      tick();
      chk(32'(irq_cause), 3, "R6 tie goes to lowest number");
      chk(32'(irq_level), 5, "R7 level raised to winner");
      chk(32'(irq_req), 0, "R5 equal priority not above level");
      rd(4'h5, 3, "R6 cause register");
      bus_wr(4'h4, 0);
      chk(32'(irq_req), 1, "R9 level restore re-enables request");

      // R9 take beats level write in one cycle
      irq_take = 1'b1;
      bus_wr(4'h4, 32'h2);
      chk(32'(irq_level), 5, "R9 take wins over level write");
      bus_wr(4'h1, 32'h0000_0208);
      bus_wr(4'h4, 0);
      chk(32'(irq_req), 0, "R3 clear by mask removes request");
      check_model("directed A");

      // R8 priority zero, then disable keeps pending
      bus_wr(4'h0, 32'h0010_0000);
      bus_wr(4'h2, 32'h0010_0000);
      chk(32'(irq_req), 0, "R8 priority zero never requests");
      bus_wr(4'hA, 32'h0001_0000);
      chk(32'(irq_req), 1, "R10 source 20 priority field");
      irq_take = 1'b1;
      tick();
      chk(32'(irq_cause), 20, "R6 cause of source 20");
      chk(32'(irq_level), 1, "R7 level of source 20");
      bus_wr(4'h4, 0);
      bus_wr(4'h3, 32'h0010_0000);
      chk(32'(irq_req), 0, "R8 disabled source masked");
      rd(4'h0, 32'h0010_0000, "R8 pending kept after disable");
      bus_wr(4'h1, 32'h0010_0000);

      // R2 software-only line ignored
      hw_irq[20] = 1'b1;
      tick();
      tick();
      rd(4'h0, 0, "R2 software-only input ignored");
      hw_irq[20] = 1'b0;

      // R3 edge beats clear; R2 held line does not re-latch
      bus_wr(4'h0, 32'h2);
      hw_irq[1] = 1'b1;
      bus_wr(4'h1, 32'h2);
      rd(4'h0, 32'h2, "R3 edge wins over clear");
      bus_wr(4'h1, 32'h2);
      tick();
      rd(4'h0, 0, "R2 held line does not re-latch");
      hw_irq[1] = 1'b0;
      tick();
      hw_irq[1] = 1'b1;
      tick();
      rd(4'h0, 32'h2, "R2 rising edge latches");
      bus_wr(4'h1, 32'h2);
      hw_irq[1] = 1'b0;

      // R7 take without request
      irq_take = 1'b1;
      tick();
      chk(32'(irq_level), 0, "R7 take without request keeps level");
      chk(32'(irq_cause), 20, "R7 take without request keeps cause");
      check_model("directed B");

      // random traffic against the model
      for (int it = 0; it < 3000; it++) begin
         hw_irq = hw_irq ^ ($urandom & $urandom & $urandom);
         irq_take = ($urandom % 3) == 0;
         r = $urandom % 10;
         reg_wr = 1'b0;
         case (r)
            0: begin reg_wr = 1; reg_addr = 4'h0; reg_wdata = $urandom & $urandom; end
            1: begin reg_wr = 1; reg_addr = 4'h1; reg_wdata = $urandom; end
            2: begin reg_wr = 1; reg_addr = 4'h2; reg_wdata = $urandom; end
            3: begin reg_wr = 1; reg_addr = 4'h3; reg_wdata = $urandom & $urandom; end
            4: begin reg_wr = 1; reg_addr = 4'h4; reg_wdata = ($urandom % 2) ? 0 : $urandom % 16; end
            5: begin reg_wr = 1; reg_addr = 4'h8 + 4'($urandom % 4); reg_wdata = $urandom; end
            default: reg_wr = 1'b0;
         endcase
         tick();
         check_model("random R6");
      end

      summary();
      $finish;
   end

endmodule